// File: doc/BRIEF.md
# Burst Address Generator

This block works out the array address for every cycle of a four-beat burst. A controller presents a base address together with a load request while the chip is selected. The block captures that address, and each later advance request steps an internal two-bit beat counter. Only the two low address bits change within a burst. The upper bits stay at the loaded base.

A static mode input picks the beat order. In linear order the low bits count up from the start offset and wrap at four. In interleaved order the low bits are the start offset XORed with the beat index. A load request seen while the chip is deselected ends the burst. A stall input freezes every register. An advance with no burst in flight does nothing.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr` is all zeros and `burst_active` is 0.
- R2: On a clock edge with `stall`=0, `adv`=0 and `sel`=1, `addr` takes the value of `ext_addr` and `burst_active` becomes 1, both visible after that edge.
- R3: With `ilv_mode`=0, the advance edges that follow a load make `addr[1:0]` equal to (start + k) mod 4 for beat k = 1, 2, 3. Here start is the loaded value of bits [1:0].
- R4: With `ilv_mode`=1, the advance edges that follow a load make `addr[1:0]` equal to start XOR k for beat k = 1, 2, 3.
- R5: An advance never changes `addr[ADDR_W-1:2]`.
- R6: The fourth advance after a load brings `addr` back to the loaded address, and the sequence then repeats.
- R7: While `adv`=1, the value on `ext_addr` has no effect on `addr`.
- R8: On an edge with `stall`=1, `addr` and `burst_active` keep their values, whatever the other inputs are.
- R9: On an edge with `stall`=0, `adv`=0 and `sel`=0, `burst_active` becomes 0 and `addr` keeps its value.
- R10: On an edge with `stall`=0 and `adv`=1 while `burst_active`=0, `addr` and `burst_active` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | 1 freezes all state for the cycle |
| adv | input | 1 | 0 = load or deselect, 1 = advance the beat |
| sel | input | 1 | Chip selected; only looked at when `adv`=0 |
| ilv_mode | input | 1 | 0 = linear order, 1 = interleaved order; static |
| ext_addr | input | ADDR_W | External base address |
| addr | output | ADDR_W | Current array address |
| burst_active | output | 1 | A burst is in flight |

## Verification
The assertions assume that `ilv_mode` does not change between resets. The linear step check depends on this, because it relates each address to the one before it under a single order. The bench therefore sets the mode only while reset is held, and runs one full pass of the sweep for each mode. The assertions also assume the inputs are free of X once reset is released, so the bench drives every input to a known value before it releases reset.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              adv,
  input  logic              sel,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              burst_active
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      start;
  logic [1:0]      beat;
  logic            active;
  logic [1:0]      low_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= '0;
      start   <= '0;
      beat    <= '0;
      active  <= 1'b0;
    end else if (!stall) begin
      if (!adv) begin
        if (sel) begin
          base_hi <= ext_addr[ADDR_W-1:2];
          start   <= ext_addr[1:0];
          beat    <= '0;
          active  <= 1'b1;
        end else begin
          active  <= 1'b0;
        end
      end else if (active) begin
        beat <= beat + 2'd1;
      end
    end
  end

  assign low_bits     = ilv_mode ? (start ^ beat) : (start + beat);
  assign addr         = {base_hi, low_bits};
  assign burst_active = active;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              adv,
  input logic              sel,
  input logic              ilv_mode,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] addr,
  input logic              burst_active
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel) |=> (addr == $past(ext_addr) && burst_active));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(addr) && $stable(burst_active)));

  // R9
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && !sel) |=> (!burst_active && $stable(addr)));

  // R10
  idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && !burst_active) |=> ($stable(addr) && !burst_active));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && burst_active) |=> $stable(addr[ADDR_W-1:2]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && burst_active && !ilv_mode) |=>
      (addr[1:0] == $past(addr[1:0]) + 2'd1));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .sel(sel),
  .ilv_mode(ilv_mode), .ext_addr(ext_addr), .addr(addr),
  .burst_active(burst_active)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          adv = 1'b1;
  logic          sel = 1'b0;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr;
  logic          burst_active;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .sel(sel),
    .ilv_mode(ilv_mode), .ext_addr(ext_addr), .addr(addr),
    .burst_active(burst_active)
  );

  task automatic check(input string req, input logic [AW-1:0] exp_a, input logic exp_act);
    checks++;
    if (addr !== exp_a || burst_active !== exp_act) begin
      errors++;
      $display("FAIL %s: addr=%0d active=%0b expected addr=%0d active=%0b",
               req, addr, burst_active, exp_a, exp_act);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic c, input logic [AW-1:0] e);
    stall = s; adv = a; sel = c; ext_addr = e;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int k, input logic m);
    logic [1:0] kk;
    kk = 2'(k);
    return {base[AW-1:2], (m ? (base[1:0] ^ kk) : (base[1:0] + kk))};
  endfunction

  task automatic do_reset(input logic m);
    rst_n = 1'b0; ilv_mode = m;
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b0, 6'h2a);
    check("R10", '0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int s = 0; s < (1 << AW); s++) begin
        logic [AW-1:0] base;
        base = AW'(s);
        step(1'b0, 1'b0, 1'b1, base);
        check("R2", base, 1'b1);
        for (int k = 1; k < 9; k++) begin
          step(1'b0, 1'b1, 1'b1, ~base);
          if (k % 4 == 0) check("R6", base, 1'b1);
          else check(m[0] ? "R4 R5 R7" : "R3 R5 R7", beat_addr(base, k, m[0]), 1'b1);
        end
        step(1'b0, 1'b1, 1'b0, base);
        check("R3 R4", beat_addr(base, 1, m[0]), 1'b1);
        step(1'b1, 1'b1, 1'b1, ~base);
        check("R8", beat_addr(base, 1, m[0]), 1'b1);
        step(1'b1, 1'b0, 1'b1, ~base);
        check("R8", beat_addr(base, 1, m[0]), 1'b1);
        step(1'b1, 1'b0, 1'b0, ~base);
        check("R8", beat_addr(base, 1, m[0]), 1'b1);
        step(1'b0, 1'b0, 1'b0, ~base);
        check("R9", beat_addr(base, 1, m[0]), 1'b0);
        step(1'b0, 1'b1, 1'b1, ~base);
        check("R10", beat_addr(base, 1, m[0]), 1'b0);
        step(1'b1, 1'b0, 1'b1, ~base);
        check("R8", beat_addr(base, 1, m[0]), 1'b0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule